// File: doc/BRIEF.md
# I2C Master Receive Engine

This block is an I2C bus master for reading from a slave. A controller steers it through a few plain pins: a control write that sets the start-request, stop-request and acknowledge-enable bits and may clear the event flag; a byte load for the address; a received-byte output; an event flag (`irq`); and an 8-bit status code. Each bus event raises `irq` and posts a one-byte code. While an event is pending the engine holds SCL low. Nothing moves on the bus until the controller clears the flag. The bits it wrote then pick the next action.

The engine generates START, repeated START and STOP. It shifts out the address byte and samples the slave's acknowledge. It clocks in data bytes MSB first, sampling SDA while SCL is high, and answers each byte with ACK or NACK according to the acknowledge-enable bit. SCL and SDA are open-drain: an `_oe` output at 1 pulls the line low. One bit takes four phases of a fixed tick derived from the clock. If a bit the engine left released reads low while SCL is high, it has lost arbitration and lets go of both lines.

All the controls are level pins or one-cycle strobes. There is no streaming handshake. The event flag is the only flow control: the controller reads `dat_rdata` and `status` while `irq` is high, then writes the control pins.

Top module: `i2c_mrx_engine`

## Requirements
- R1: After reset, `irq` is 0, `status` reads 0xF8, and both `scl_oe` and `sda_oe` are 0. Whenever `irq` is 0, `status` reads 0xF8.
- R2: A control write with start-request=1 while the engine is idle produces a START once both lines read high. The START is SDA falling while SCL is high, then SCL pulled low. The engine then raises `irq` with status 0x08. A START issued from a held bus reports 0x10 instead.
- R3: Clearing the flag after 0x08 or 0x10 sends the loaded byte MSB first and then releases SDA for the acknowledge. If bit 0 of the byte is 1 (read), the result is 0x40 when SDA is sampled low and 0x48 when it is sampled high.
- R4: Clearing the flag after 0x40 or 0x50 receives eight bits MSB first. The engine drives ACK (SDA low) on the ninth bit if acknowledge-enable=1, giving status 0x50, and leaves SDA released otherwise, giving status 0x58. `dat_rdata` shows the byte and stays stable while `irq` is 1.
- R5: While `irq` is 1 with any status other than 0x38, `scl_oe` is 1. No bus transition happens until the flag is cleared.
- R6: Clearing the flag after 0x48, 0x58, 0x18 or 0x20 acts on the request bits. Stop only gives a STOP and then idle, with both lines released and status 0xF8. Start only gives a repeated START and status 0x10. Both set gives a STOP and then a fresh START with status 0x08. The stop request is consumed by the STOP.
- R7: Clearing the flag after 0x10 with bit 0 of the loaded byte at 0 (write) sends that byte and reports 0x18 on ACK or 0x20 on NACK.
- R8: If SDA reads low while SCL is high during a bit the engine left released (an address bit of 1, or a NACK answer), the engine releases both lines and reports 0x38. Clearing with start-request=1 retries the START when the bus is free, giving 0x08. Clearing with start-request=0 leaves it idle with status 0xF8.
- R9: In the states listed in R6, clearing with neither request bit set sends a STOP and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| ctl_we | input | 1 | Strobe: capture the three request bits below |
| ctl_start | input | 1 | Start-request bit |
| ctl_stop | input | 1 | Stop-request bit |
| ctl_ack | input | 1 | Acknowledge-enable for received bytes |
| ctl_flag_clr | input | 1 | With ctl_we, clear the event flag |
| dat_we | input | 1 | Strobe: load the address byte |
| dat_wdata | input | 8 | Address byte, bit 0 = read(1)/write(0) |
| dat_rdata | output | 8 | Last received byte |
| irq | output | 1 | Event flag |
| status | output | 8 | Event code, 0xF8 when no event |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong phase or bit count shows up on the bus as a misplaced START or STOP edge that the bench slave decodes. It also shows up as a wrong received byte or a wrong acknowledge code at the next `irq`, within one byte time. A wrong decision in the held state appears as the wrong status code at the very next event, or as lines left driven after a STOP. An arbitration check at the wrong place either loses the race silently or reports 0x38 on a clean bus.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;
  localparam int BYTE_W = 8;
  localparam int FRAME_BITS = BYTE_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BITS, ST_HOLD, ST_STOP, ST_LOST
  } eng_st_t;

  localparam logic [7:0] CODE_START   = 8'h08;
  localparam logic [7:0] CODE_RSTART  = 8'h10;
  localparam logic [7:0] CODE_AW_ACK  = 8'h18;
  localparam logic [7:0] CODE_AW_NACK = 8'h20;
  localparam logic [7:0] CODE_ARB     = 8'h38;
  localparam logic [7:0] CODE_AR_ACK  = 8'h40;
  localparam logic [7:0] CODE_AR_NACK = 8'h48;
  localparam logic [7:0] CODE_RX_ACK  = 8'h50;
  localparam logic [7:0] CODE_RX_NACK = 8'h58;
  localparam logic [7:0] CODE_NONE    = 8'hF8;
endpackage

// File: rtl/i2c_mrx_tick.sv
module i2c_mrx_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_mrx_shift.sv
module i2c_mrx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= ld_val;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/i2c_mrx_engine.sv
module i2c_mrx_engine
  import i2c_mrx_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic       ctl_start,
  input  logic       ctl_stop,
  input  logic       ctl_ack,
  input  logic       ctl_flag_clr,
  input  logic       dat_we,
  input  logic [7:0] dat_wdata,
  output logic [7:0] dat_rdata,
  output logic       irq,
  output logic [7:0] status,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int BN_W = $clog2(FRAME_BITS + 1);
  localparam logic [BN_W-1:0] ACK_SLOT = BN_W'(BYTE_W);

  eng_st_t           st;
  logic [1:0]        ph;
  logic [BN_W-1:0]   bitn;
  logic              rx_kind, rd_bit, rep, ack_seen;
  logic              sta_r, sto_r, aa_r;
  logic [7:0]        code, txb, rxb;
  logic              tick, sh_load, sh_shift;
  logic [BYTE_W-1:0] sh_q;
  logic              drv_low, released, lost;

  i2c_mrx_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  i2c_mrx_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .ld_val(txb),
    .shift(sh_shift), .sin(sda_i), .q(sh_q)
  );

  always_comb begin
    sh_load  = tick && (st == ST_HOLD) && !irq &&
               ((code == CODE_START) || (code == CODE_RSTART));
    sh_shift = tick && (st == ST_BITS) && (ph == 2'd2) && (bitn < ACK_SLOT);
    if (rx_kind) drv_low = (bitn == ACK_SLOT) ? aa_r : 1'b0;
    else         drv_low = (bitn == ACK_SLOT) ? 1'b0 : !sh_q[BYTE_W-1];
    if (rx_kind) released = (bitn == ACK_SLOT) && !aa_r;
    else         released = (bitn < ACK_SLOT) && sh_q[BYTE_W-1];
    lost = released && !sda_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= '0; bitn <= '0;
      rx_kind <= 1'b0; rd_bit <= 1'b0; rep <= 1'b0; ack_seen <= 1'b0;
      sta_r <= 1'b0; sto_r <= 1'b0; aa_r <= 1'b0;
      code <= CODE_NONE; txb <= '0; rxb <= '0;
      irq <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (dat_we) txb <= dat_wdata;
      if (ctl_we) begin
        sta_r <= ctl_start;
        sto_r <= ctl_stop;
        aa_r  <= ctl_ack;
        if (ctl_flag_clr) irq <= 1'b0;
      end
      if (tick) begin
        ph <= ph + 2'd1;
        unique case (st)
          ST_IDLE: begin
            ph <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0;
            if (sta_r && !irq && scl_i && sda_i) begin
              st <= ST_START; rep <= 1'b0;
            end
          end
          ST_START: begin
            case (ph)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              2'd3: begin
                scl_oe <= 1'b1; sta_r <= 1'b0; irq <= 1'b1;
                code <= rep ? CODE_RSTART : CODE_START;
                st <= ST_HOLD;
              end
            endcase
          end
          ST_HOLD: begin
            ph <= '0;
            if (!irq) begin
              bitn <= '0;
              if ((code == CODE_START) || (code == CODE_RSTART)) begin
                st <= ST_BITS; rx_kind <= 1'b0; rd_bit <= txb[0];
              end else if ((code == CODE_AR_ACK) || (code == CODE_RX_ACK)) begin
                st <= ST_BITS; rx_kind <= 1'b1;
              end else if (sta_r && !sto_r) begin
                st <= ST_START; rep <= 1'b1;
              end else begin
                st <= ST_STOP;
              end
            end
          end
          ST_BITS: begin
            case (ph)
              2'd0: sda_oe <= drv_low;
              2'd1: scl_oe <= 1'b0;
              2'd2: begin
                if (lost) begin
                  st <= ST_LOST; sda_oe <= 1'b0; scl_oe <= 1'b0;
                  irq <= 1'b1; code <= CODE_ARB; ph <= '0;
                end else if (bitn == ACK_SLOT) begin
                  ack_seen <= !sda_i;
                end
              end
              2'd3: begin
                scl_oe <= 1'b1;
                if (bitn == ACK_SLOT) begin
                  st <= ST_HOLD; irq <= 1'b1;
                  if (rx_kind) begin
                    rxb  <= sh_q;
                    code <= aa_r ? CODE_RX_ACK : CODE_RX_NACK;
                  end else if (rd_bit) begin
                    code <= ack_seen ? CODE_AR_ACK : CODE_AR_NACK;
                  end else begin
                    code <= ack_seen ? CODE_AW_ACK : CODE_AW_NACK;
                  end
                end else begin
                  bitn <= bitn + 1'b1;
                end
              end
            endcase
          end
          ST_STOP: begin
            case (ph)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              2'd3: begin sto_r <= 1'b0; st <= ST_IDLE; end
            endcase
          end
          ST_LOST: begin
            ph <= '0;
            if (!irq) st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign dat_rdata = rxb;
  assign status    = irq ? code : CODE_NONE;

  AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && status != CODE_ARB) |-> scl_oe);  // R5
  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && status == CODE_ARB) |-> (!scl_oe && !sda_oe));  // R8
  AST_RX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (!irq || $stable(dat_rdata)));  // R4
  AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!scl_oe && !sda_oe));  // R6
  AST_START_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_IDLE && st == ST_START) |-> $past(scl_i && sda_i));  // R2
endmodule

// File: tb/tb_i2c_mrx_engine.sv
module tb_i2c_mrx_engine;
  localparam int DIV = 4;
  localparam logic [6:0] SADDR = 7'h50;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ctl_we, ctl_start, ctl_stop, ctl_ack, ctl_flag_clr, dat_we;
  logic [7:0] dat_wdata, dat_rdata, status;
  logic irq, scl_oe, sda_oe;
  logic s_drv, jam;
  logic scl_bus, sda_bus;
  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe || s_drv || jam);

  i2c_mrx_engine #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_start(ctl_start),
    .ctl_stop(ctl_stop), .ctl_ack(ctl_ack), .ctl_flag_clr(ctl_flag_clr),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .irq(irq), .status(status), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int total = 0, bad = 0;

  function automatic logic [7:0] pat(int i);
    return 8'(90 + i * 37);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus slave: address 0x50, streams pat(0), pat(1), ... on reads
  logic pscl, psda, mack;
  logic [7:0] sr, tx;
  int bc, sidx, smode, stops;
  always @(negedge clk) begin
    if (!rst_n) begin
      pscl = 1'b1; psda = 1'b1; s_drv = 1'b0; smode = 0; bc = 0;
      stops = 0; sr = '0; tx = '0; mack = 1'b0; sidx = 0;
    end else begin
      if (pscl && scl_bus && psda && !sda_bus) begin
        smode = 1; bc = -1; s_drv = 1'b0;
      end else if (pscl && scl_bus && !psda && sda_bus) begin
        smode = 0; s_drv = 1'b0; stops++;
      end else if (!pscl && scl_bus) begin
        if (smode == 1 && bc >= 0 && bc < 8) sr = {sr[6:0], sda_bus};
        if (smode == 2 && bc == 8) mack = !sda_bus;
      end else if (pscl && !scl_bus) begin
        bc++;
        if (smode == 1) begin
          if (bc == 8) s_drv = (sr[7:1] == SADDR);
          else if (bc == 9) begin
            s_drv = 1'b0;
            if (sr[7:1] != SADDR) smode = 0;
            else if (sr[0]) begin
              smode = 2; bc = 0; sidx = 0; tx = pat(0); s_drv = !tx[7];
            end else smode = 3;
          end
        end else if (smode == 2) begin
          if (bc < 8) s_drv = !tx[7-bc];
          else if (bc == 8) s_drv = 1'b0;
          else if (mack) begin
            sidx++; tx = pat(sidx); bc = 0; s_drv = !tx[7];
          end else begin
            smode = 0; s_drv = 1'b0;
          end
        end
      end
      pscl = scl_bus; psda = sda_bus;
    end
  end

  // scoreboard
  typedef struct {
    logic [7:0] code;
    logic [7:0] data;
    bit         use_data;
    string      req;
  } exp_t;
  exp_t expq[$];
  int seen = 0;
  logic pirq = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq && !pirq) begin
        if (expq.size() == 0) begin
          check(1'b0, "R5", "unexpected event status", int'(status), 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(status == e.code, e.req, "status", int'(status), int'(e.code));
          if (e.use_data)
            check(dat_rdata == e.data, e.req, "rx byte", int'(dat_rdata), int'(e.data));
        end
        seen++;
      end
      pirq = irq;
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [7:0] b);
    @(negedge clk); dat_we = 1'b1; dat_wdata = b;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic step(bit s, bit p, bit a, bit c, logic [7:0] code,
                      logic [7:0] data, bit ud, string req);
    int tgt;
    exp_t e;
    e.code = code; e.data = data; e.use_data = ud; e.req = req;
    expq.push_back(e);
    tgt = seen + 1;
    @(negedge clk);
    ctl_we = 1'b1; ctl_start = s; ctl_stop = p; ctl_ack = a; ctl_flag_clr = c;
    @(negedge clk);
    ctl_we = 1'b0;
    wait (seen >= tgt);
  endtask

  task automatic ctl_only(bit s, bit p, bit a, bit c);
    @(negedge clk);
    ctl_we = 1'b1; ctl_start = s; ctl_stop = p; ctl_ack = a; ctl_flag_clr = c;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic check_idle(string req, int stops_exp);
    wait_clk(60);
    check(!irq, req, "irq after stop", int'(irq), 0);
    check(status == 8'hF8, req, "status after stop", int'(status), 8'hF8);
    check(!scl_oe && !sda_oe, req, "lines released", int'({scl_oe, sda_oe}), 0);
    check(stops == stops_exp, req, "stop count", stops, stops_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "ALL", "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_start = 1'b0; ctl_stop = 1'b0;
    ctl_ack = 1'b0; ctl_flag_clr = 1'b0; dat_we = 1'b0; dat_wdata = '0; jam = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R1 reset state
    check(!irq, "R1", "irq", int'(irq), 0);
    check(status == 8'hF8, "R1", "status", int'(status), 8'hF8);
    check(!scl_oe && !sda_oe, "R1", "lines", int'({scl_oe, sda_oe}), 0);

    // R2 start from idle, R5 hold
    load({SADDR, 1'b1});
    step(1, 0, 1, 0, 8'h08, 8'h00, 0, "R2");
    wait_clk(80);
    check(scl_oe && !scl_bus && irq && status == 8'h08, "R5", "scl held", int'(scl_oe), 1);
    check(stops == 0, "R5", "no bus action", stops, 0);
    // R3 address ack, R4 receive
    step(0, 0, 1, 1, 8'h40, 8'h00, 0, "R3");
    step(0, 0, 1, 1, 8'h50, pat(0), 1, "R4");
    step(0, 0, 1, 1, 8'h50, pat(1), 1, "R4");
    step(0, 0, 0, 1, 8'h58, pat(2), 1, "R4");
    wait_clk(100);
    check(dat_rdata == pat(2) && irq, "R4", "byte stable while held", int'(dat_rdata), int'(pat(2)));
    // R6 stop only
    ctl_only(0, 1, 0, 1);
    check_idle("R6", 1);

    // R3 address nack, R6 restart, R7 write address
    load(8'h47);
    step(1, 0, 1, 0, 8'h08, 8'h00, 0, "R2");
    step(0, 0, 1, 1, 8'h48, 8'h00, 0, "R3");
    load({SADDR, 1'b0});
    step(1, 0, 1, 1, 8'h10, 8'h00, 0, "R6");
    step(0, 0, 1, 1, 8'h18, 8'h00, 0, "R7");
    load({SADDR, 1'b1});
    step(1, 1, 1, 1, 8'h08, 8'h00, 0, "R6");
    check(stops == 2, "R6", "stop before start", stops, 2);
    step(0, 0, 0, 1, 8'h40, 8'h00, 0, "R3");
    step(0, 0, 0, 1, 8'h58, pat(0), 1, "R4");
    // R9 neither bit
    ctl_only(0, 0, 0, 1);
    check_idle("R9", 3);

    // R8 arbitration loss, retry
    step(1, 0, 1, 0, 8'h08, 8'h00, 0, "R2");
    jam = 1'b1;
    step(0, 0, 1, 1, 8'h38, 8'h00, 0, "R8");
    wait_clk(20);
    check(!scl_oe && !sda_oe, "R8", "lines released after loss", int'({scl_oe, sda_oe}), 0);
    jam = 1'b0;
    wait_clk(10);
    step(1, 0, 1, 1, 8'h08, 8'h00, 0, "R8");
    step(0, 0, 0, 1, 8'h40, 8'h00, 0, "R3");
    step(0, 0, 0, 1, 8'h58, pat(0), 1, "R4");
    ctl_only(0, 1, 0, 1);
    check_idle("R6", 5);

    // R8 loss then give up
    step(1, 0, 1, 0, 8'h08, 8'h00, 0, "R2");
    jam = 1'b1;
    step(0, 0, 1, 1, 8'h38, 8'h00, 0, "R8");
    jam = 1'b0;
    wait_clk(10);
    ctl_only(0, 0, 0, 1);
    check_idle("R8", 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule